// File: doc/BRIEF.md
# SPI Nonvolatile Memory Slave Controller

This block is the device-side serial interface of a byte-addressed nonvolatile memory whose writes complete at bus speed. It listens on the SPI pins (clock, serial in, active-low chip select), decodes one command per select frame, and moves bytes between the serial line and an internal array through a synchronous byte-wide port. It also keeps the write-enable latch and a small status register, runs an auto-incrementing burst address counter that wraps circularly, and drives the serial output with a separate output enable so that a pad can tri-state it.

All SPI inputs are synchronised into the system clock domain, and the block acts on their edges. Bits are taken on the rising SCK edge and shifted out on the falling edge, so SPI modes 0 and 3 both work without any setting. The active-low HOLD input pauses the bus. The active-low WP input, when armed by a status bit, protects the status register. Identification and serial-number reads return constant bytes set by parameters. For the smallest density, a parameter of one address byte makes bit 3 of the opcode carry address bit 8.

Top module: `spi_nvmem_slave`

## Requirements
- R1: SI is taken on a rising SCK edge and SO changes only after a falling SCK edge, most-significant bit first. Modes 0 and 3 both work. so_oe is low whenever CS is high and high while CS is low.
- R2: Opcode 0x06 sets the write-enable latch, which becomes visible only after CS rises at the end of that frame.
- R3: Opcode 0x04 clears the write-enable latch when CS rises.
- R4: With the latch clear, WRITE (0x02), status write (0x01) and SLEEP (0xB9) have no effect on the array, the status register or sleep_o.
- R5: When an accepted WRITE, status write or SLEEP frame ends, the latch is clear. A status read leaves the latch unchanged.
- R6: Status read (0x05) returns bit7 = write-protect arm, bits 3:2 = two free user bits, bit1 = latch, and 0 in the other bits. The byte repeats for as long as the frame lasts.
- R7: READ (0x03) and WRITE take the address most-significant byte first and ignore address bits above the array size. The address advances by one per data byte and wraps from the top address to 0.
- R8: FAST READ (0x0B) expects one dummy byte after the address. The first data byte follows that dummy byte.
- R9: With ADDR_BYTES = 1 there is a single address byte and opcode bit 3 is address bit 8. So 0x0B and 0x0A read and write the upper half of the array.
- R10: When the write-protect arm bit is 1 and wp_n is low, a status write leaves the status unchanged. When the arm bit is 0, wp_n has no effect.
- R11: While hold_n is low, SCK edges are ignored. The frame resumes where it stopped.
- R12: Opcode 0x9F returns the 9 bytes of ID_VAL, high byte first, and opcode 0xC3 returns the 8 bytes of SN_VAL. Both give 0x00 after the last byte.
- R13: Only the first byte after CS falls is decoded as a command. An unknown opcode makes the rest of the frame inert.
- R14: An accepted SLEEP raises sleep_o when CS rises, and the next falling edge of CS lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low status write protect |
| hold_n | input | 1 | Active-low bus pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| mem_addr | output | MEM_AW | Array byte address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, registered one clock after mem_addr |
| sleep_o | output | 1 | Sleep mode flag |

## Verification
A rising edge of CS can commit several effects of a frame in the same clock: clearing the latch after an accepted SLEEP, and entering sleep. The bench provokes this by ending an enabled SLEEP frame. It checks that sleep_o is high after the edge and that a following status read shows the latch clear. A second collision is a HOLD pause in the middle of a burst write, which comes between a byte's shift and its array write. The bench pulses SCK while paused and then reads the location back, expecting the byte sent after the pause.

// File: rtl/spi_nvmem_slave.sv
module spi_nvmem_slave #(
  parameter int          ADDR_BYTES = 2,
  parameter int          MEM_AW     = 10,
  parameter logic [71:0] ID_VAL     = 72'hA1_B2_C3_D4_E5_F6_07_18_29,
  parameter logic [63:0] SN_VAL     = 64'h01_23_45_67_89_AB_CD_EF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wp_n,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              sleep_o
);
  localparam bit         SMALL = (ADDR_BYTES == 1);
  localparam logic [1:0] ALAST = 2'(ADDR_BYTES - 1);

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_DUMMY, ST_WDATA, ST_WSTAT, ST_STREAM, ST_SKIP} st_t;
  typedef enum logic [1:0] {SRC_STAT, SRC_MEM, SRC_ID, SRC_SN} src_t;

  logic [4:0] s1, s2;
  logic       sck_p, cs_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 5'b10011; s2 <= 5'b10011; sck_p <= 1'b0; cs_p <= 1'b1;
    end else begin
      s1 <= {cs_n, sck, si, hold_n, wp_n}; s2 <= s1; sck_p <= s2[3]; cs_p <= s2[4];
    end

  logic cs_s, sck_s, si_s, hold_s, wp_s;
  assign {cs_s, sck_s, si_s, hold_s, wp_s} = s2;

  logic act, rise, fall, cs_up, cs_dn;
  assign act   = !cs_s && hold_s;
  assign rise  = act && sck_s && !sck_p;
  assign fall  = act && !sck_s && sck_p;
  assign cs_up = cs_s && !cs_p;
  assign cs_dn = !cs_s && cs_p;

  st_t               state;
  src_t              src;
  logic [6:0]        rx_sh;
  logic [2:0]        bit_cnt;
  logic [7:0]        tx_sh;
  logic              load_pend;
  logic [MEM_AW-1:0] addr_r;
  logic [1:0]        acnt;
  logic [15:0]       ashift;
  logic              fast, wr_mode;
  logic [3:0]        idx;
  logic              wel, wpen;
  logic [1:0]        ubits;
  logic              set_pend, clr_pend, slp_pend, sleep_r;
  logic              we_r;
  logic [7:0]        wdata_r;

  logic [7:0]        rx_byte;
  logic              byte_done;
  logic [7:0]        status_byte;
  logic [MEM_AW-1:0] addr_nxt;
  assign rx_byte     = {rx_sh, si_s};
  assign byte_done   = rise && (bit_cnt == 3'd7);
  assign status_byte = {wpen, 3'b000, ubits, wel, 1'b0};
  assign addr_nxt    = MEM_AW'({ashift, rx_byte});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_CMD; src <= SRC_STAT; rx_sh <= '0; bit_cnt <= '0; tx_sh <= '0;
      load_pend <= 1'b0; addr_r <= '0; acnt <= '0; ashift <= '0; fast <= 1'b0;
      wr_mode <= 1'b0; idx <= '0; wel <= 1'b0; wpen <= 1'b0; ubits <= '0;
      set_pend <= 1'b0; clr_pend <= 1'b0; slp_pend <= 1'b0; sleep_r <= 1'b0;
      we_r <= 1'b0; wdata_r <= '0;
    end else begin
      we_r <= 1'b0;
      if (we_r) addr_r <= addr_r + 1'b1;
      if (cs_up) begin
        state <= ST_CMD; bit_cnt <= '0; load_pend <= 1'b0;
        if (set_pend) wel <= 1'b1;
        else if (clr_pend) wel <= 1'b0;
        if (slp_pend) sleep_r <= 1'b1;
        set_pend <= 1'b0; clr_pend <= 1'b0; slp_pend <= 1'b0;
      end else if (cs_dn) begin
        sleep_r <= 1'b0;
      end
      if (rise) begin
        rx_sh   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (fall) begin
        if (load_pend) begin
          load_pend <= 1'b0;
          case (src)
            SRC_STAT: tx_sh <= status_byte;
            SRC_MEM: begin tx_sh <= mem_rdata; addr_r <= addr_r + 1'b1; end
            SRC_ID: begin
              tx_sh <= 8'((ID_VAL << {idx, 3'b000}) >> 64);
              if (idx != 4'hF) idx <= idx + 1'b1;
            end
            default: begin
              tx_sh <= 8'((SN_VAL << {idx, 3'b000}) >> 56);
              if (idx != 4'hF) idx <= idx + 1'b1;
            end
          endcase
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
      if (byte_done) begin
        case (state)
          ST_CMD: begin
            fast <= 1'b0; wr_mode <= 1'b0; acnt <= '0; idx <= '0; ashift <= '0;
            state <= ST_SKIP;
            if (SMALL && rx_byte[7:4] == 4'h0 && rx_byte[2:1] == 2'b01) begin
              ashift <= {15'd0, rx_byte[3]};
              if (rx_byte[0]) state <= ST_ADDR;
              else if (wel) begin state <= ST_ADDR; wr_mode <= 1'b1; clr_pend <= 1'b1; end
            end else begin
              case (rx_byte)
                8'h06: set_pend <= 1'b1;
                8'h04: clr_pend <= 1'b1;
                8'h05: begin state <= ST_STREAM; src <= SRC_STAT; load_pend <= 1'b1; end
                8'h01: if (wel) begin state <= ST_WSTAT; clr_pend <= 1'b1; end
                8'h03: state <= ST_ADDR;
                8'h0B: begin state <= ST_ADDR; fast <= 1'b1; end
                8'h02: if (wel) begin state <= ST_ADDR; wr_mode <= 1'b1; clr_pend <= 1'b1; end
                8'hB9: if (wel) begin slp_pend <= 1'b1; clr_pend <= 1'b1; end
                8'h9F: begin state <= ST_STREAM; src <= SRC_ID; load_pend <= 1'b1; end
                8'hC3: begin state <= ST_STREAM; src <= SRC_SN; load_pend <= 1'b1; end
                default: ;
              endcase
            end
          end
          ST_ADDR: begin
            ashift <= {ashift[7:0], rx_byte};
            acnt   <= acnt + 1'b1;
            if (acnt == ALAST) begin
              addr_r <= addr_nxt;
              if (wr_mode) state <= ST_WDATA;
              else if (fast) state <= ST_DUMMY;
              else begin state <= ST_STREAM; src <= SRC_MEM; load_pend <= 1'b1; end
            end
          end
          ST_DUMMY: begin state <= ST_STREAM; src <= SRC_MEM; load_pend <= 1'b1; end
          ST_WDATA: begin we_r <= 1'b1; wdata_r <= rx_byte; end
          ST_WSTAT: begin
            if (!(wpen && !wp_s)) begin wpen <= rx_byte[7]; ubits <= rx_byte[3:2]; end
            state <= ST_SKIP;
          end
          ST_STREAM: load_pend <= 1'b1;
          default: ;
        endcase
      end
    end

  assign so        = tx_sh[7];
  assign so_oe     = !cs_s;
  assign mem_addr  = addr_r;
  assign mem_we    = we_r;
  assign mem_wdata = wdata_r;
  assign sleep_o   = sleep_r;

  // R1
  tx_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(tx_sh));
  // R2
  wel_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_up |=> $stable(wel));
  // R4
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);
  // R10
  status_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_s) |=> $stable(wpen) && $stable(ubits));
  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_s) |=> $stable(bit_cnt) && $stable(rx_sh));
  // R14
  sleep_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(cs_up));
endmodule

// File: tb/test_spi_nvmem_slave.sv
module test_spi_nvmem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_a = 1'b1, cs_b = 1'b1, wp_n = 1'b1, hold_n = 1'b1;
  logic so_a, oe_a, we_a, sl_a, so_b, oe_b, we_b, sl_b;
  logic [9:0] ad_a;
  logic [8:0] ad_b;
  logic [7:0] wd_a, rd_a, wd_b, rd_b;
  logic [7:0] mem_a [1024];
  logic [7:0] mem_b [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_nvmem_slave i_spi_nvmem_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_a), .si(si), .wp_n(wp_n), .hold_n(hold_n),
    .so(so_a), .so_oe(oe_a), .mem_addr(ad_a), .mem_we(we_a), .mem_wdata(wd_a),
    .mem_rdata(rd_a), .sleep_o(sl_a));

  spi_nvmem_slave #(.ADDR_BYTES(1), .MEM_AW(9)) i_small (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_b), .si(si), .wp_n(wp_n), .hold_n(hold_n),
    .so(so_b), .so_oe(oe_b), .mem_addr(ad_b), .mem_we(we_b), .mem_wdata(wd_b),
    .mem_rdata(rd_b), .sleep_o(sl_b));

  initial begin
    for (int i = 0; i < 1024; i++) mem_a[i] = 8'(i) ^ 8'h3C;
    for (int i = 0; i < 512; i++) mem_b[i] = 8'(i) ^ 8'h3C;
  end
  always @(posedge clk) begin
    if (we_a) mem_a[ad_a] <= wd_a;
    rd_a <= mem_a[ad_a];
    if (we_b) mem_b[ad_b] <= wd_b;
    rd_b <= mem_b[ad_b];
  end

  int n_vec = 0, n_bad = 0;
  bit tgt_b = 1'b0, cpol = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  initial forever begin
    wait (got_q.size() > 0);
    begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      n_vec++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s: SO byte got %02h expected %02h", t, g, e);
      end
    end
  end

  task automatic xbyte(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string req);
    logic [7:0] got;
    if (chk) begin exp_q.push_back(exp); tag_q.push_back(req); end
    for (int i = 7; i >= 0; i--) begin
      if (cpol) sck = 1'b0;
      si = tx[i];
      repeat (HALF) @(negedge clk);
      got[i] = tgt_b ? so_b : so_a;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!cpol) sck = 1'b0;
    end
    if (chk) got_q.push_back(got);
  endtask

  task automatic cmd(input logic [7:0] b);
    xbyte(b, 1'b0, 8'h00, "");
  endtask

  task automatic fstart();
    sck = cpol;
    repeat (2) @(negedge clk);
    if (tgt_b) cs_b = 1'b0; else cs_a = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic fend();
    repeat (HALF) @(negedge clk);
    cs_a = 1'b1; cs_b = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wren();
    fstart(); cmd(8'h06); fend();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string req);
    fstart(); cmd(8'h05); xbyte(8'h00, 1'b1, exp, req); fend();
  endtask

  task automatic finish_run();
    wait (got_q.size() == 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    got_q.delete();
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 R14 reset state
    check({7'd0, oe_a}, 8'h00, "R1 so_oe at reset");
    check({7'd0, sl_a}, 8'h00, "R14 sleep_o at reset");
    check({7'd0, we_a}, 8'h00, "R4 mem_we at reset");

    rdsr(8'h00, "R6 status after reset");
    // R4 write with latch clear is ignored
    fstart(); cmd(8'h02); cmd(8'h00); cmd(8'h10); cmd(8'hAA); fend();
    fstart(); cmd(8'h03); cmd(8'h00); cmd(8'h10); xbyte(8'h00, 1'b1, 8'h2C, "R4 write ignored"); fend();

    // R2 latch set, R5 status read keeps it, R6 repeats
    wren();
    fstart(); cmd(8'h05);
    xbyte(8'h00, 1'b1, 8'h02, "R2 latch set after CS rise");
    check({7'd0, oe_a}, 8'h01, "R1 so_oe while selected");
    xbyte(8'h00, 1'b1, 8'h02, "R6 status repeats"); fend();
    check({7'd0, oe_a}, 8'h00, "R1 so_oe after deselect");
    rdsr(8'h02, "R5 status read keeps latch");

    // R7 truncated address, burst write
    fstart(); cmd(8'h02); cmd(8'hFC); cmd(8'h0E); cmd(8'h11); cmd(8'h22); cmd(8'h33); fend();
    rdsr(8'h00, "R5 latch cleared after write");
    fstart(); cmd(8'h03); cmd(8'h00); cmd(8'h0E);
    xbyte(8'h00, 1'b1, 8'h11, "R7 burst byte 0");
    xbyte(8'h00, 1'b1, 8'h22, "R7 burst byte 1");
    xbyte(8'h00, 1'b1, 8'h33, "R7 burst byte 2");
    xbyte(8'h00, 1'b1, 8'h2D, "R7 burst byte 3"); fend();

    // R3
    wren();
    fstart(); cmd(8'h04); fend();
    rdsr(8'h00, "R3 latch cleared");

    // R7 wrap
    wren();
    fstart(); cmd(8'h02); cmd(8'h03); cmd(8'hFF); cmd(8'h5A); cmd(8'hA5); fend();
    fstart(); cmd(8'h03); cmd(8'h03); cmd(8'hFF);
    xbyte(8'h00, 1'b1, 8'h5A, "R7 top address");
    xbyte(8'h00, 1'b1, 8'hA5, "R7 wrapped to 0");
    xbyte(8'h00, 1'b1, 8'h3D, "R7 after wrap"); fend();

    // R8
    fstart(); cmd(8'h0B); cmd(8'h00); cmd(8'h0E); cmd(8'hFF);
    xbyte(8'h00, 1'b1, 8'h11, "R8 first after dummy");
    xbyte(8'h00, 1'b1, 8'h22, "R8 second"); fend();

    // R10
    wren();
    fstart(); cmd(8'h01); cmd(8'h8C); fend();
    rdsr(8'h8C, "R6 status fields");
    wp_n = 1'b0;
    wren();
    fstart(); cmd(8'h01); cmd(8'h00); fend();
    rdsr(8'h8C, "R10 locked status");
    wp_n = 1'b1;
    wren();
    fstart(); cmd(8'h01); cmd(8'h00); fend();
    rdsr(8'h00, "R10 unlocked status");
    wp_n = 1'b0;
    wren();
    fstart(); cmd(8'h01); cmd(8'h0C); fend();
    rdsr(8'h0C, "R10 wp ignored when disarmed");
    wren();
    fstart(); cmd(8'h01); cmd(8'h00); fend();
    wp_n = 1'b1;
    // R4 status write without latch
    fstart(); cmd(8'h01); cmd(8'h80); fend();
    rdsr(8'h00, "R4 status write ignored");

    // R12
    fstart(); cmd(8'h9F);
    for (int k = 0; k < 9; k++) xbyte(8'h00, 1'b1, 8'(72'hA1_B2_C3_D4_E5_F6_07_18_29 >> (64 - 8*k)), "R12 id byte");
    xbyte(8'h00, 1'b1, 8'h00, "R12 past id"); fend();
    fstart(); cmd(8'hC3);
    for (int k = 0; k < 8; k++) xbyte(8'h00, 1'b1, 8'(64'h01_23_45_67_89_AB_CD_EF >> (56 - 8*k)), "R12 serial byte");
    xbyte(8'h00, 1'b1, 8'h00, "R12 past serial"); fend();

    // R13
    fstart(); cmd(8'hFF); cmd(8'h06); fend();
    rdsr(8'h00, "R13 unknown opcode frame inert");
    fstart(); cmd(8'h05); xbyte(8'h06, 1'b1, 8'h00, "R13 later byte not a command"); fend();
    rdsr(8'h00, "R13 latch untouched");

    // R11
    wren();
    fstart(); cmd(8'h02); cmd(8'h00); cmd(8'h20);
    hold_n = 1'b0; si = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
    cmd(8'h77); fend();
    fstart(); cmd(8'h03); cmd(8'h00); cmd(8'h20); xbyte(8'h00, 1'b1, 8'h77, "R11 hold pause"); fend();

    // R14
    fstart(); cmd(8'hB9); fend();
    check({7'd0, sl_a}, 8'h00, "R4 sleep refused");
    wren();
    fstart(); cmd(8'hB9);
    check({7'd0, sl_a}, 8'h00, "R14 no sleep before CS rise");
    fend();
    check({7'd0, sl_a}, 8'h01, "R14 sleep entered");
    fstart();
    check({7'd0, sl_a}, 8'h00, "R14 wake on select");
    cmd(8'h05); xbyte(8'h00, 1'b1, 8'h00, "R5 latch cleared by sleep"); fend();

    // R1 mode 3
    cpol = 1'b1;
    fstart(); cmd(8'h03); cmd(8'h00); cmd(8'h0E);
    xbyte(8'h00, 1'b1, 8'h11, "R1 mode 3 read");
    xbyte(8'h00, 1'b1, 8'h22, "R1 mode 3 burst"); fend();
    cpol = 1'b0;

    // R9
    tgt_b = 1'b1;
    wren();
    fstart(); cmd(8'h0A); cmd(8'h05); cmd(8'h99); fend();
    fstart(); cmd(8'h03); cmd(8'h05); xbyte(8'h00, 1'b1, 8'h39, "R9 lower half"); fend();
    fstart(); cmd(8'h0B); cmd(8'h05); xbyte(8'h00, 1'b1, 8'h99, "R9 upper half"); fend();
    fstart(); cmd(8'h0B); cmd(8'hFF);
    xbyte(8'h00, 1'b1, 8'hC3, "R9 top of small array");
    xbyte(8'h00, 1'b1, 8'h3C, "R7 small array wrap"); fend();
    tgt_b = 1'b0;

    finish_run();
  end
endmodule